// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block picks divider settings for a display clock synthesiser. Software, or a mode-setting sequencer, presents the wanted pixel clock in kHz and pulses a start strobe. The engine chooses a DAC multiplier from the pixel clock and forms a search target of pixel clock times multiplier, in Hz. It then walks the whole divisor space of the PLL in a fixed order, one candidate per clock. For each candidate it computes the VCO and dot frequencies with two pipelined dividers, rejects any candidate that breaks a limit, and keeps the best one.

An exact hit on the target ends the walk early. Otherwise the winner is the candidate whose dot clock lies above the target by the smallest margin. When the search ends, the engine raises `done` and holds the chosen divisors. It also holds a packed divisor word and a packed multiplier word, ready to be written into the PLL control registers. Programming the analog PLL itself is left to the caller.

The reference clock is 96 MHz, and the post divider p2 is fixed at 10. The frequencies are: VCO = floor(96e6·(5·m1+m2)/n) and dot = floor(VCO/(p1·p2)).

Top module: `pll_div_search`

## Requirements
- R1: After reset, `done` and `found` are 0, and every divisor output and both packed words are 0.
- R2: The multiplier is 1 for a pixel clock of 100000 kHz or more, 2 for 50000 kHz up to 99999 kHz, and 4 below 50000 kHz. The search target is pixel_kHz·1000·multiplier Hz. When a result is found, `multiplier_word` holds (multiplier−1) in bits 7:0 and again in bits 15:8, and its other bits are 0.
- R3: A pixel clock below 25000 kHz starts no search. `done` rises within 4 cycles of the strobe, with `found` at 0.
- R4: A reported candidate meets every limit: n in 3..8, m1 in 10..20, m2 in 5..9, p1 in 1..8, m1 > m2, m=5·m1+m2 in 70..120, p=p1·10 in 5..80, VCO in 1.4e9..2.8e9 Hz, and dot in 20e6..400e6 Hz.
- R5: Candidates are visited with n rising in the outermost loop, then m1, m2 and p1 each falling, nested in that order. The first candidate whose dot clock equals the target is reported, and the walk stops early.
- R6: Without an exact hit, the reported candidate is the one whose dot clock exceeds the target by the least. The difference must be below 0xFFFFFFFF. On a tie, the earliest candidate in visiting order wins.
- R7: If no candidate qualifies, `done` rises with `found` at 0, and all divisor outputs and both words are 0.
- R8: `divisor_word` holds (m2−2) in bits 7:0, (m1−2) in bits 15:8 and (n−2) in bits 23:16, with bits 31:24 at 0. `div_p2` reads 10 when a result is found.
- R9: `done` stays high, with its outputs held, until the next start. A start that arrives while a search runs is ignored.
- R10: A candidate is issued every clock, so a full search completes within 2740 cycles of the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken only when no search runs |
| pix_clk_khz | input | 20 | Requested pixel clock in kHz, sampled with the strobe |
| done | output | 1 | Search finished; held until the next start |
| found | output | 1 | A qualifying candidate was chosen |
| div_n | output | 4 | Chosen n |
| div_m1 | output | 5 | Chosen m1 |
| div_m2 | output | 4 | Chosen m2 |
| div_p1 | output | 4 | Chosen p1 |
| div_p2 | output | 4 | Post divider (10 when found) |
| divisor_word | output | 32 | Packed n, m1 and m2 field word |
| multiplier_word | output | 32 | Packed DAC multiplier word |

## Verification
The bench builds the engine with its default parameters: a 96 MHz reference, the full divisor limits and a 20-bit pixel input. This brings the complete space of 2640 candidates into every run, so the early exit on an exact hit can be seen directly in a shortened latency. The multiplier thresholds at 50000 kHz and 100000 kHz, and the 25000 kHz floor, can each be hit on both sides. A pixel clock whose target lies beyond the 400 MHz dot ceiling exercises the no-result path.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int N_W  = 4;
  localparam int M1_W = 5;
  localparam int M2_W = 4;
  localparam int P1_W = 4;
  localparam int P2_W = 4;
  localparam int M_W  = 8;
  localparam int P_W  = 8;
  localparam int FQ_W = 34;

  typedef struct packed {
    logic [N_W-1:0]  n;
    logic [M1_W-1:0] m1;
    logic [M2_W-1:0] m2;
    logic [P1_W-1:0] p1;
    logic            pre_ok;
  } cand_t;

  localparam int CAND_W = $bits(cand_t);

  typedef enum logic [1:0] {
    SS_IDLE  = 2'd0,
    SS_WALK  = 2'd1,
    SS_DRAIN = 2'd2,
    SS_DONE  = 2'd3
  } srch_state_t;
endpackage

// File: rtl/pll_mult_sel.sv
module pll_mult_sel
  import pll_search_pkg::*;
#(
  parameter int PIX_W     = 20,
  parameter int MIN_KHZ   = 25000,
  parameter int MULT1_KHZ = 100000,
  parameter int MULT2_KHZ = 50000
) (
  input  logic [PIX_W-1:0] pix_khz,
  output logic [2:0]       mult,
  output logic [FQ_W-1:0]  target,
  output logic             too_low
);
  always_comb begin
    if (pix_khz >= PIX_W'(MULT1_KHZ))      mult = 3'd1;
    else if (pix_khz >= PIX_W'(MULT2_KHZ)) mult = 3'd2;
    else                                   mult = 3'd4;
  end

  assign target  = FQ_W'(pix_khz) * FQ_W'(1000) * FQ_W'(mult);
  assign too_low = (pix_khz < PIX_W'(MIN_KHZ));
endmodule

// File: rtl/pll_cand_walk.sv
module pll_cand_walk
  import pll_search_pkg::*;
#(
  parameter int N_LO   = 3,
  parameter int N_HI   = 8,
  parameter int M1_LO  = 10,
  parameter int M1_HI  = 20,
  parameter int M2_LO  = 5,
  parameter int M2_HI  = 9,
  parameter int P1_LO  = 1,
  parameter int P1_HI  = 8,
  parameter int P2_FIX = 10,
  parameter int M_LO   = 70,
  parameter int M_HI   = 120,
  parameter int P_LO   = 5,
  parameter int P_HI   = 80
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           halt,
  output logic           walk_busy,
  output logic           cand_vld,
  output cand_t          cand,
  output logic [M_W-1:0] cand_m
);
  logic [N_W-1:0]  n_q;
  logic [M1_W-1:0] m1_q;
  logic [M2_W-1:0] m2_q;
  logic [P1_W-1:0] p1_q;
  logic [P_W-1:0]  p_w;
  logic            last_w;

  assign cand_m = M_W'(m1_q) * M_W'(5) + M_W'(m2_q);
  assign p_w    = P_W'(p1_q) * P_W'(P2_FIX);
  assign last_w = (n_q == N_W'(N_HI)) && (m1_q == M1_W'(M1_LO)) &&
                  (m2_q == M2_W'(M2_LO)) && (p1_q == P1_W'(P1_LO));

  always_comb begin
    cand.n  = n_q;
    cand.m1 = m1_q;
    cand.m2 = m2_q;
    cand.p1 = p1_q;
    cand.pre_ok = (n_q  >= N_W'(N_LO))   && (n_q  <= N_W'(N_HI))   &&
                  (m1_q >= M1_W'(M1_LO)) && (m1_q <= M1_W'(M1_HI)) &&
                  (m2_q >= M2_W'(M2_LO)) && (m2_q <= M2_W'(M2_HI)) &&
                  (p1_q >= P1_W'(P1_LO)) && (p1_q <= P1_W'(P1_HI)) &&
                  (M_W'(m1_q) > M_W'(m2_q)) &&
                  (cand_m >= M_W'(M_LO)) && (cand_m <= M_W'(M_HI)) &&
                  (p_w >= P_W'(P_LO)) && (p_w <= P_W'(P_HI));
  end

  assign cand_vld = walk_busy && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      walk_busy <= 1'b0;
      n_q  <= '0;
      m1_q <= '0;
      m2_q <= '0;
      p1_q <= '0;
    end else if (go) begin
      walk_busy <= 1'b1;
      n_q  <= N_W'(N_LO);
      m1_q <= M1_W'(M1_HI);
      m2_q <= M2_W'(M2_HI);
      p1_q <= P1_W'(P1_HI);
    end else if (walk_busy) begin
      if (halt || last_w) begin
        walk_busy <= 1'b0;
      end else if (p1_q != P1_W'(P1_LO)) begin
        p1_q <= p1_q - 1'b1;
      end else begin
        p1_q <= P1_W'(P1_HI);
        if (m2_q != M2_W'(M2_LO)) begin
          m2_q <= m2_q - 1'b1;
        end else begin
          m2_q <= M2_W'(M2_HI);
          if (m1_q != M1_W'(M1_LO)) begin
            m1_q <= m1_q - 1'b1;
          end else begin
            m1_q <= M1_W'(M1_HI);
            n_q  <= n_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pll_pipe_div.sv
// Restoring divider, one quotient bit per stage, NW stages of latency.
module pll_pipe_div #(
  parameter int NW = 34,
  parameter int DW = 4,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [NW-1:0] in_num,
  input  logic [DW-1:0] in_den,
  input  logic [TW-1:0] in_tag,
  output logic          out_vld,
  output logic [NW-1:0] out_quo,
  output logic [TW-1:0] out_tag,
  output logic          busy
);
  logic          r_vld [NW];
  logic [NW-1:0] r_num [NW];
  logic [NW-1:0] r_quo [NW];
  logic [DW-1:0] r_rem [NW];
  logic [DW-1:0] r_den [NW];
  logic [TW-1:0] r_tag [NW];

  logic          s_vld [NW];
  logic [NW-1:0] s_num [NW];
  logic [NW-1:0] s_quo [NW];
  logic [DW-1:0] s_rem [NW];
  logic [DW-1:0] s_den [NW];
  logic [TW-1:0] s_tag [NW];

  logic [NW-1:0] n_quo [NW];
  logic [DW-1:0] n_rem [NW];

  always_comb begin
    s_vld[0] = in_vld;
    s_num[0] = in_num;
    s_quo[0] = '0;
    s_rem[0] = '0;
    s_den[0] = in_den;
    s_tag[0] = in_tag;
    for (int k = 1; k < NW; k++) begin
      s_vld[k] = r_vld[k-1];
      s_num[k] = r_num[k-1];
      s_quo[k] = r_quo[k-1];
      s_rem[k] = r_rem[k-1];
      s_den[k] = r_den[k-1];
      s_tag[k] = r_tag[k-1];
    end
  end

  always_comb begin
    for (int k = 0; k < NW; k++) begin
      logic [DW:0] sh;
      logic        ge;
      sh = {s_rem[k], s_num[k][NW-1-k]};
      ge = (sh >= {1'b0, s_den[k]});
      n_quo[k] = s_quo[k];
      n_quo[k][NW-1-k] = ge;
      n_rem[k] = ge ? DW'(sh - {1'b0, s_den[k]}) : sh[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NW; k++) begin
      r_vld[k] <= rst ? 1'b0 : s_vld[k];
      r_num[k] <= s_num[k];
      r_quo[k] <= n_quo[k];
      r_rem[k] <= n_rem[k];
      r_den[k] <= s_den[k];
      r_tag[k] <= s_tag[k];
    end
  end

  always_comb begin
    busy = 1'b0;
    for (int k = 0; k < NW; k++) busy = busy | r_vld[k];
  end

  assign out_vld = r_vld[NW-1];
  assign out_quo = r_quo[NW-1];
  assign out_tag = r_tag[NW-1];
endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep
  import pll_search_pkg::*;
#(
  parameter logic [FQ_W-1:0] VCO_LO    = 34'd1_400_000_000,
  parameter logic [FQ_W-1:0] VCO_HI    = 34'd2_800_000_000,
  parameter logic [FQ_W-1:0] DOT_LO    = 34'd20_000_000,
  parameter logic [FQ_W-1:0] DOT_HI    = 34'd400_000_000,
  parameter logic [FQ_W-1:0] DIFF_INIT = 34'h0_FFFF_FFFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            enable,
  input  logic            in_vld,
  input  cand_t           in_cand,
  input  logic [FQ_W-1:0] in_vco,
  input  logic [FQ_W-1:0] in_dot,
  input  logic [FQ_W-1:0] target,
  output cand_t           best,
  output logic            best_vld,
  output logic            exact_hit
);
  logic [FQ_W-1:0] best_diff;
  logic            ok_w;
  logic [FQ_W-1:0] diff_w;

  assign ok_w = in_vld && enable && !exact_hit && in_cand.pre_ok &&
                (in_vco >= VCO_LO) && (in_vco <= VCO_HI) &&
                (in_dot >= DOT_LO) && (in_dot <= DOT_HI);
  assign diff_w = in_dot - target;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      best      <= '0;
      best_vld  <= 1'b0;
      exact_hit <= 1'b0;
      best_diff <= DIFF_INIT;
    end else if (ok_w) begin
      if (in_dot == target) begin
        best      <= in_cand;
        best_vld  <= 1'b1;
        exact_hit <= 1'b1;
        best_diff <= '0;
      end else if ((in_dot > target) && (diff_w < best_diff)) begin
        best      <= in_cand;
        best_vld  <= 1'b1;
        best_diff <= diff_w;
      end
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int PIX_W     = 20,
  parameter int REF_HZ    = 96_000_000,
  parameter int N_LO      = 3,
  parameter int N_HI      = 8,
  parameter int M1_LO     = 10,
  parameter int M1_HI     = 20,
  parameter int M2_LO     = 5,
  parameter int M2_HI     = 9,
  parameter int P1_LO     = 1,
  parameter int P1_HI     = 8,
  parameter int P2_FIX    = 10,
  parameter int M_LO      = 70,
  parameter int M_HI      = 120,
  parameter int P_LO      = 5,
  parameter int P_HI      = 80,
  parameter int MIN_KHZ   = 25000,
  parameter int MULT1_KHZ = 100000,
  parameter int MULT2_KHZ = 50000,
  parameter logic [33:0] VCO_LO = 34'd1_400_000_000,
  parameter logic [33:0] VCO_HI = 34'd2_800_000_000,
  parameter logic [33:0] DOT_LO = 34'd20_000_000,
  parameter logic [33:0] DOT_HI = 34'd400_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PIX_W-1:0] pix_clk_khz,
  output logic             done,
  output logic             found,
  output logic [3:0]       div_n,
  output logic [4:0]       div_m1,
  output logic [3:0]       div_m2,
  output logic [3:0]       div_p1,
  output logic [3:0]       div_p2,
  output logic [31:0]      divisor_word,
  output logic [31:0]      multiplier_word
);
  localparam int T2_W = FQ_W + CAND_W;

  srch_state_t     state_q;
  logic [2:0]      mult_w, mult_q;
  logic [FQ_W-1:0] target_w, target_q;
  logic            low_w, start_ok;

  logic            walk_busy, cand_vld;
  cand_t           cand;
  logic [M_W-1:0]  cand_m;

  logic            d1_vld, d1_busy, d2_vld, d2_busy;
  logic [FQ_W-1:0] d1_quo, d2_quo;
  logic [CAND_W-1:0] d1_tag;
  logic [T2_W-1:0] d2_tag;
  cand_t           d1_c, d2_c;
  logic [FQ_W-1:0] d2_vco;

  cand_t           best;
  logic            best_vld, exact_hit, keep_en;

  pll_mult_sel #(
    .PIX_W(PIX_W), .MIN_KHZ(MIN_KHZ), .MULT1_KHZ(MULT1_KHZ), .MULT2_KHZ(MULT2_KHZ)
  ) u_mult (
    .pix_khz(pix_clk_khz), .mult(mult_w), .target(target_w), .too_low(low_w)
  );

  assign start_ok = start && ((state_q == SS_IDLE) || (state_q == SS_DONE));

  pll_cand_walk #(
    .N_LO(N_LO), .N_HI(N_HI), .M1_LO(M1_LO), .M1_HI(M1_HI),
    .M2_LO(M2_LO), .M2_HI(M2_HI), .P1_LO(P1_LO), .P1_HI(P1_HI),
    .P2_FIX(P2_FIX), .M_LO(M_LO), .M_HI(M_HI), .P_LO(P_LO), .P_HI(P_HI)
  ) u_walk (
    .clk(clk), .rst(rst), .go(start_ok && !low_w), .halt(exact_hit),
    .walk_busy(walk_busy), .cand_vld(cand_vld), .cand(cand), .cand_m(cand_m)
  );

  // VCO = ref * m / n
  pll_pipe_div #(.NW(FQ_W), .DW(N_W), .TW(CAND_W)) u_div_vco (
    .clk(clk), .rst(rst), .in_vld(cand_vld),
    .in_num(FQ_W'(REF_HZ) * FQ_W'(cand_m)), .in_den(cand.n), .in_tag(cand),
    .out_vld(d1_vld), .out_quo(d1_quo), .out_tag(d1_tag), .busy(d1_busy)
  );

  assign d1_c = cand_t'(d1_tag);

  // dot = VCO / (p1 * p2)
  pll_pipe_div #(.NW(FQ_W), .DW(P_W), .TW(T2_W)) u_div_dot (
    .clk(clk), .rst(rst), .in_vld(d1_vld),
    .in_num(d1_quo), .in_den(P_W'(d1_c.p1) * P_W'(P2_FIX)), .in_tag({d1_quo, d1_tag}),
    .out_vld(d2_vld), .out_quo(d2_quo), .out_tag(d2_tag), .busy(d2_busy)
  );

  assign d2_vco = d2_tag[T2_W-1:CAND_W];
  assign d2_c   = cand_t'(d2_tag[CAND_W-1:0]);
  assign keep_en = (state_q == SS_WALK) || (state_q == SS_DRAIN);

  pll_best_keep #(
    .VCO_LO(VCO_LO), .VCO_HI(VCO_HI), .DOT_LO(DOT_LO), .DOT_HI(DOT_HI)
  ) u_keep (
    .clk(clk), .rst(rst), .clear(start_ok), .enable(keep_en),
    .in_vld(d2_vld), .in_cand(d2_c), .in_vco(d2_vco), .in_dot(d2_quo),
    .target(target_q), .best(best), .best_vld(best_vld), .exact_hit(exact_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= SS_IDLE;
      mult_q          <= 3'd1;
      target_q        <= '0;
      done            <= 1'b0;
      found           <= 1'b0;
      div_n           <= '0;
      div_m1          <= '0;
      div_m2          <= '0;
      div_p1          <= '0;
      div_p2          <= '0;
      divisor_word    <= '0;
      multiplier_word <= '0;
    end else begin
      case (state_q)
        SS_IDLE, SS_DONE: begin
          if (start_ok) begin
            state_q         <= low_w ? SS_DRAIN : SS_WALK;
            mult_q          <= mult_w;
            target_q        <= target_w;
            done            <= 1'b0;
            found           <= 1'b0;
            div_n           <= '0;
            div_m1          <= '0;
            div_m2          <= '0;
            div_p1          <= '0;
            div_p2          <= '0;
            divisor_word    <= '0;
            multiplier_word <= '0;
          end
        end
        SS_WALK: begin
          if (!walk_busy) state_q <= SS_DRAIN;
        end
        default: begin
          if (!d1_busy && !d2_busy && !walk_busy) begin
            state_q <= SS_DONE;
            done    <= 1'b1;
            found   <= best_vld;
            if (best_vld) begin
              div_n           <= best.n;
              div_m1          <= best.m1;
              div_m2          <= best.m2;
              div_p1          <= best.p1;
              div_p2          <= 4'(P2_FIX);
              divisor_word    <= {8'd0, 8'(best.n) - 8'd2, 8'(best.m1) - 8'd2,
                                  8'(best.m2) - 8'd2};
              multiplier_word <= {16'd0, 8'(mult_q) - 8'd1, 8'(mult_q) - 8'd1};
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int N_LO   = 3,
  parameter int N_HI   = 8,
  parameter int P2_FIX = 10
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        done,
  input logic        found,
  input logic [3:0]  div_n,
  input logic [4:0]  div_m1,
  input logic [3:0]  div_m2,
  input logic [3:0]  div_p2,
  input logic [31:0] divisor_word,
  input logic [31:0] multiplier_word
);
  p_found_needs_done_r7: assert property (@(posedge clk) disable iff (rst)
    found |-> done);

  p_m1_above_m2_r4: assert property (@(posedge clk) disable iff (rst)
    found |-> (div_m1 > 5'(div_m2)));

  p_n_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    found |-> ((div_n >= 4'(N_LO)) && (div_n <= 4'(N_HI))));

  p_p2_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    found |-> (div_p2 == 4'(P2_FIX)));

  p_word_n_field_r8: assert property (@(posedge clk) disable iff (rst)
    found |-> (divisor_word[23:16] == 8'(div_n) - 8'd2));

  p_mult_halves_r2: assert property (@(posedge clk) disable iff (rst)
    multiplier_word[7:0] == multiplier_word[15:8]);

  p_zero_when_lost_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> ((divisor_word == 32'd0) && (div_n == 4'd0)));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(divisor_word)));

  p_start_drops_done_r9: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !done);
endmodule

bind pll_div_search pll_div_search_chk #(
  .N_LO(N_LO), .N_HI(N_HI), .P2_FIX(P2_FIX)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .found(found),
  .div_n(div_n), .div_m1(div_m1), .div_m2(div_m2), .div_p2(div_p2),
  .divisor_word(divisor_word), .multiplier_word(multiplier_word)
);

// File: tb/sim_pll_div_search.sv
`timescale 1ns/1ps
module sim_pll_div_search;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [19:0] pix_clk_khz = '0;
  logic        done, found;
  logic [3:0]  div_n, div_m2, div_p1, div_p2;
  logic [4:0]  div_m1;
  logic [31:0] divisor_word, multiplier_word;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pll_div_search u0 (
    .clk(clk), .rst(rst), .start(start), .pix_clk_khz(pix_clk_khz),
    .done(done), .found(found), .div_n(div_n), .div_m1(div_m1),
    .div_m2(div_m2), .div_p1(div_p1), .div_p2(div_p2),
    .divisor_word(divisor_word), .multiplier_word(multiplier_word)
  );

  typedef struct packed {
    int n; int m1; int m2; int p1; int found; int mult; int exact; int idx;
  } exp_t;

  function automatic exp_t model(input int pix);
    exp_t e;
    longint tgt, vco, dot, best, m, p;
    int idx;
    e = '0;
    e.mult = (pix >= 100000) ? 1 : ((pix >= 50000) ? 2 : 4);
    if (pix < 25000) return e;
    tgt  = longint'(pix) * 1000 * e.mult;
    best = 64'h0FFFF_FFFF;
    idx  = 0;
    for (int n = 3; n <= 8; n++)
      for (int m1 = 20; m1 >= 10; m1--)
        for (int m2 = 9; m2 >= 5; m2--)
          for (int p1 = 8; p1 >= 1; p1--) begin
            m = 5 * m1 + m2;
            p = p1 * 10;
            if (m1 > m2 && m >= 70 && m <= 120 && p >= 5 && p <= 80) begin
              vco = (64'd96000000 * m) / n;
              dot = vco / p;
              if (vco >= 64'd1400000000 && vco <= 64'd2800000000 &&
                  dot >= 64'd20000000 && dot <= 64'd400000000) begin
                if (dot == tgt) begin
                  e.n = n; e.m1 = m1; e.m2 = m2; e.p1 = p1;
                  e.found = 1; e.exact = 1; e.idx = idx;
                  return e;
                end
                if (dot > tgt && (dot - tgt) < best) begin
                  best = dot - tgt;
                  e.n = n; e.m1 = m1; e.m2 = m2; e.p1 = p1; e.found = 1;
                end
              end
            end
            idx++;
          end
    return e;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Pulse start with pix; optionally pulse a second start at cycle alt_at.
  task automatic do_search(input int pix, input int alt_pix, input int alt_at,
                           output int lat);
    @(negedge clk);
    pix_clk_khz = 20'(pix);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 6000) begin
      @(negedge clk);
      lat++;
      if (alt_at > 0 && lat == alt_at) begin
        pix_clk_khz = 20'(alt_pix);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  task automatic verify(input int pix, input int lat);
    exp_t e;
    longint vco, dot, tgt;
    e = model(pix);
    chk("R9 done raised", longint'(done), 1);
    chk(e.found != 0 ? "R6 found" : "R7 found", longint'(found), e.found);
    chk("R5 n",  div_n,  e.n);
    chk("R5 m1", div_m1, e.m1);
    chk("R6 m2", div_m2, e.m2);
    chk("R6 p1", div_p1, e.p1);
    chk("R8 p2", div_p2, e.found != 0 ? 10 : 0);
    chk("R8 divisor word", divisor_word,
        e.found != 0 ? ((longint'(e.n - 2) << 16) | (longint'(e.m1 - 2) << 8) |
                        longint'(e.m2 - 2)) : 0);
    chk("R2 multiplier word", multiplier_word,
        e.found != 0 ? ((longint'(e.mult - 1) << 8) | longint'(e.mult - 1)) : 0);
    if (pix < 25000) begin
      chk("R3 short latency", longint'(lat <= 4), 1);
    end else begin
      chk("R10 latency bound", longint'(lat <= 2740), 1);
    end
    if (e.exact != 0 && e.idx + 200 < 2640)
      chk("R5 early exit", longint'(lat < 2640), 1);
    if (found) begin
      tgt = longint'(pix) * 1000 * e.mult;
      vco = (64'd96000000 * (5 * div_m1 + div_m2)) / div_n;
      dot = vco / (div_p1 * 10);
      chk("R4 limits met", longint'(vco >= 64'd1400000000 && vco <= 64'd2800000000 &&
          dot >= 64'd20000000 && dot <= 64'd400000000 && div_m1 > div_m2 &&
          dot >= tgt), 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    int dirs[10] = '{24999, 25000, 49999, 50000, 99999, 100000, 65400,
                     500000, 400000, 1000};
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 done", done, 0);
    chk("R1 found", found, 0);
    chk("R1 divisor word", divisor_word, 0);
    chk("R1 multiplier word", multiplier_word, 0);
    chk("R1 n", div_n, 0);

    foreach (dirs[i]) begin
      do_search(dirs[i], 0, 0, lat);
      verify(dirs[i], lat);
    end

    // R9: done and outputs held while start stays low
    begin
      logic [31:0] w;
      w = divisor_word;
      repeat (20) @(negedge clk);
      chk("R9 done held", done, 1);
      chk("R9 word held", divisor_word, w);
    end

    // R9: a start during a running search is ignored
    do_search(200000, 30000, 60, lat);
    verify(200000, lat);

    for (int r = 0; r < 16; r++) begin
      int pix;
      pix = int'($urandom_range(420000, 25000));
      do_search(pix, 0, 0, lat);
      verify(pix, lat);
    end

    finish_run();
  end
endmodule